// File: doc/BRIEF.md
# Sequential Shift-and-Add Unsigned Multiplier

This block multiplies two unsigned N-bit operands (N defaults to 8). It examines one bit of the multiplier per iteration. A small five-state sequencer steps a datapath through the work. The datapath holds the multiplicand in a parallel register. It also holds an accumulator with a carry bit above it, and the multiplier in a shift register whose low bits are gradually replaced by product bits. The 2N-bit result is the accumulator on top of the shift register.

A client pulses `start` while `done` is high, with both operands valid on the inputs. The sequencer takes the operands one cycle later, in its load state. It then alternates between testing the multiplier's low bit, an optional accumulate step, and a combined shift-and-count step. After the N-th shift it returns to rest and raises `done` again. The product then stays on `product` until the next accepted start.

Top module: `shiftadd_mul`

## Requirements
- R1: After reset, `done` is 1 and `product` is 0.
- R2: A `start` sampled high while `done` is 1 is accepted. `done` is 0 from the next cycle until the operation completes.
- R3: When `done` returns to 1, `product` equals the unsigned product of the two operands, with the high N bits from the accumulator and the low N bits from the shift register. For N=8, 0x89 times 0xAB gives 0x5B83.
- R4: For each 1 bit in the multiplier, the sequencer spends one cycle in the accumulate state, and it passes through test and shift-and-count once for every bit. `done` rises exactly 2N+2+popcount(multiplier) clock edges after the edge that accepts `start`. The worst case is 3N+2.
- R5: A `start` pulse while `done` is 0 is ignored. It changes neither the result nor the latency.
- R6: The operand inputs are sampled only at the clock edge that ends the load state, which is the second edge after `start` is accepted. Changes after that edge have no effect on the running operation.
- R7: While at rest and with no `start`, `done` stays 1 and `product` stays unchanged.
- R8: Zero operands give 0, and all-ones operands give (2^N-1)^2, which is 0xFE01 for N=8.
- R9: A `start` sampled on the very first cycle after `done` rises is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin request, honoured only while at rest |
| mcand_in | input | N | Multiplicand operand |
| mplier_in | input | N | Multiplier operand |
| product | output | 2N | Result: accumulator over the shift register |
| done | output | 1 | High while at rest with the result available |

## Verification
The final shift-and-count step does two things in the same cycle: it shifts in the last product bit, and it sees the counter reach N, which sends the machine back to rest. A new `start` can then land on the first resting cycle. The bench launches every operation on the cycle right after it sees `done` rise. For each operation it compares both the product and the exact edge count against values computed from the operands. An off-by-one in the stop condition or a lost back-to-back start therefore shows up as a wrong product or a wrong latency. Mid-run start pulses and operand changes after the load edge are checked the same way: the expected result must stay that of the original operands.

// File: rtl/shiftadd_pkg.sv
package shiftadd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_TEST,
        ST_ADD,
        ST_SHIFT
    } sa_state_e;

    typedef struct packed {
        logic load;
        logic add;
        logic shift;
    } sa_ctrl_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/shiftadd_ctrl.sv
module shiftadd_ctrl
    import shiftadd_pkg::*;
#(
    parameter int unsigned N  = 8,
    localparam int unsigned CW = cnt_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          q_lsb,
    output sa_ctrl_t      ctl,
    output sa_state_e     state,
    output logic [CW-1:0] cnt,
    output logic          done
);

    localparam logic [CW-1:0] LAST = CW'(N - 1);

    sa_state_e state_nx;
    logic      last_iter;

    assign last_iter = (cnt == LAST);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_INIT;
            ST_INIT:  state_nx = ST_TEST;
            ST_TEST:  state_nx = q_lsb ? ST_ADD : ST_SHIFT;
            ST_ADD:   state_nx = ST_SHIFT;
            ST_SHIFT: state_nx = last_iter ? ST_IDLE : ST_TEST;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_INIT)
                cnt <= '0;
            else if (state == ST_SHIFT)
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        ctl.load  = (state == ST_INIT);
        ctl.add   = (state == ST_ADD);
        ctl.shift = (state == ST_SHIFT);
    end

    assign done = (state == ST_IDLE);

endmodule

// File: rtl/shiftadd_dp.sv
module shiftadd_dp
    import shiftadd_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  sa_ctrl_t       ctl,
    input  logic [N-1:0]   mcand_in,
    input  logic [N-1:0]   mplier_in,
    output logic           q_lsb,
    output logic [2*N-1:0] product
);

    logic [N-1:0] m_reg;
    logic [N-1:0] acc;
    logic [N-1:0] q_reg;
    logic         carry;
    logic [N:0]   sum;

    assign sum = {1'b0, acc} + {1'b0, m_reg};

    always_ff @(posedge clk) begin
        if (rst) begin
            m_reg <= '0;
            acc   <= '0;
            q_reg <= '0;
            carry <= 1'b0;
        end else if (ctl.load) begin
            m_reg <= mcand_in;
            q_reg <= mplier_in;
            acc   <= '0;
            carry <= 1'b0;
        end else if (ctl.add) begin
            {carry, acc} <= sum;
        end else if (ctl.shift) begin
            {carry, acc, q_reg} <= {1'b0, carry, acc, q_reg[N-1:1]};
        end
    end

    assign q_lsb   = q_reg[0];
    assign product = {acc, q_reg};

endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul
    import shiftadd_pkg::*;
#(
    parameter int unsigned N  = 8,
    localparam int unsigned CW = cnt_width(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N-1:0]   mcand_in,
    input  logic [N-1:0]   mplier_in,
    output logic [2*N-1:0] product,
    output logic           done
);

    sa_ctrl_t      ctl;
    sa_state_e     state;
    logic [CW-1:0] cnt;
    logic          q_lsb;

    shiftadd_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .q_lsb (q_lsb),
        .ctl   (ctl),
        .state (state),
        .cnt   (cnt),
        .done  (done)
    );

    shiftadd_dp #(.N(N)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mcand_in  (mcand_in),
        .mplier_in (mplier_in),
        .q_lsb     (q_lsb),
        .product   (product)
    );

endmodule

// File: rtl/shiftadd_mul_chk.sv
module shiftadd_mul_chk
    import shiftadd_pkg::*;
#(
    parameter int unsigned N  = 8,
    localparam int unsigned CW = cnt_width(N)
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           done,
    input logic [2*N-1:0] product,
    input sa_state_e      state,
    input logic [CW-1:0]  cnt
);

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        done && start |=> !done);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done && $stable(product));

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        !done && start && state != ST_SHIFT |=> !done);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= int'(N));

    // R4
    add_then_shift_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_ADD |=> state == ST_SHIFT);

    // R3
    test_zero_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_TEST && !product[0] |=> state == ST_SHIFT);

endmodule

bind shiftadd_mul shiftadd_mul_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .done    (done),
    .product (product),
    .state   (state),
    .cnt     (cnt)
);

// File: tb/shiftadd_mul_bench.sv
module shiftadd_mul_bench;

    localparam int unsigned N = 8;

    typedef struct {
        logic [2*N-1:0] prod;
        int             lat;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [N-1:0]   mcand_in = '0;
    logic [N-1:0]   mplier_in = '0;
    logic [2*N-1:0] product;
    logic           done;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 0;
    exp_t sb[$];

    always #5 clk = ~clk;

    shiftadd_mul #(.N(N)) u_shiftadd_mul (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mcand_in  (mcand_in),
        .mplier_in (mplier_in),
        .product   (product),
        .done      (done)
    );

    task automatic check(input bit ok, input string req,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // Driver: called at a negedge; returns at the negedge where done is seen high.
    task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b,
                          input bit disturb);
        exp_t e;
        e.prod = (2*N)'(a) * (2*N)'(b);
        e.lat  = 2 + 2*N + $countones(b);
        sb.push_back(e);
        mcand_in  = a;
        mplier_in = b;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        if (disturb) begin
            // R5 R6: late start pulse and operand change must be ignored
            mcand_in  = ~a;
            mplier_in = ~b;
            start     = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    // Monitor / scoreboard
    bit             busy = 0;
    bit             have_last = 0;
    int             cyc = 0;
    logic [2*N-1:0] last_prod;

    always @(negedge clk) begin
        if (!rst) begin
            if (!done) begin
                if (!busy) begin
                    busy = 1;
                    cyc  = 1;
                end else begin
                    cyc++;
                end
            end else if (busy) begin
                exp_t e;
                busy = 0;
                if (sb.size() == 0) begin
                    check(0, "R3 unexpected completion", product, 0);
                end else begin
                    e = sb.pop_front();
                    // R3 R8: product value
                    check(product == e.prod, "R3/R8 product", product, e.prod);
                    // R4 R9: latency from accepting edge
                    check(cyc + 1 == e.lat, "R4 latency", cyc + 1, e.lat);
                end
                last_prod = product;
                have_last = 1;
            end else if (have_last && !start) begin
                // R7: result held at rest
                check(product == last_prod, "R7 hold", product, last_prod);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(done == 1'b1, "R1 done after reset", done, 1);
        check(product == '0, "R1 product after reset", product, 0);

        run_op(8'h89, 8'hAB, 0);   // R3 worked example
        run_op(8'h00, 8'hFF, 0);   // R8 zero multiplicand
        run_op(8'hFF, 8'h00, 0);   // R8 zero multiplier
        run_op(8'hFF, 8'hFF, 0);   // R8 all ones, worst-case latency R4
        run_op(8'h01, 8'h80, 0);
        run_op(8'h80, 8'h01, 0);
        run_op(8'h5A, 8'hC3, 1);   // R5 R6 disturbance
        repeat (6) @(negedge clk); // R7 idle gap
        run_op(8'h37, 8'h7E, 0);
        for (int i = 0; i < 24; i++) begin
            run_op(N'($urandom), N'($urandom), (i % 5) == 0);  // R9 back to back
        end
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R3 all results seen", sb.size(), 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule